// File: doc/BRIEF.md
# Normalized Duty to Tick Converter

This block turns a duty-cycle command, given as a single-precision IEEE-754 number that is normally between 0.0 and 1.0, into an unsigned 16-bit duty count in timer ticks that a PWM comparator can use directly. The float is first reduced to a signed 16-bit fixed-point word with one integer bit and fifteen fraction bits. That word is then multiplied by the current PWM period in ticks, and the integer part of the product is kept.

The command arrives on a stream that carries only a valid strobe. There is no back-pressure. The block accepts a word in every cycle in which `cmd_valid` is high, including back-to-back cycles, and never stalls. The result leaves on a valid-qualified output two clock cycles later. The scaling multiply advances only when a converted word is present. Between updates the duty output holds its last value, so a change of the period input alone does not move the output.

Top module: `duty_tick_conv`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `duty_valid` is 0 and `duty_ticks` is 0.
- R2: A command accepted with `cmd_valid` high at clock edge k gives `duty_valid` high after edge k+1. Back-to-back commands give back-to-back results in the same order.
- R3: A command with the sign bit (bit 31) set, a NaN (exponent bits 30:23 all ones with a nonzero mantissa in bits 22:0), zero, or a subnormal value gives a fixed-point duty of 0 and therefore `duty_ticks` = 0.
- R4: A non-negative command at or above 1.0, including +infinity (exponent field 127 or larger), saturates to the fixed-point value 0x7FFF. The fixed-point word never has its sign bit set.
- R5: For a normal value in [0,1), the fixed-point duty equals floor(value × 32768). Extra mantissa bits are truncated, not rounded. Values below 2^-15 give 0.
- R6: `duty_ticks` equals bits 30:15 of the product of the fixed-point duty and `period`. `period` is sampled on the cycle the multiply is enabled, one cycle after the command is accepted. For a nonzero period the result is always below the period.
- R7: When `duty_valid` is low, `duty_ticks` holds its previous value, whatever `period` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid strobe; no ready, accepted every cycle |
| cmd_float | input | 32 | Single-precision duty command |
| period | input | 16 | PWM period in ticks (unsigned) |
| duty_valid | output | 1 | One-cycle strobe marking a new duty result |
| duty_ticks | output | 16 | Duty in ticks; holds between strobes |

## Verification
Several properties are checked on every cycle. These are the two-stage valid pipeline, the zeroing of negative commands, the saturation of large ones, the clear sign bit of the fixed-point word, the result staying below a nonzero period, and the output holding between strobes. Exact tick values are left to the directed scenarios. Those values are the floor-and-truncate arithmetic on specific encodings such as 0.3, 1/3 and 2^-15, the handling of NaN and infinity, and full-range periods. So is the ordering of back-to-back commands and the proof that a period change without a command leaves the output unchanged.

// File: rtl/duty_conv_pkg.sv
package duty_conv_pkg;
  parameter int FLT_W = 32;
  parameter int EXP_W = 8;
  parameter int MAN_W = 23;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;
  } flt_t;

  typedef enum logic [1:0] {
    KIND_ZERO   = 2'd0,
    KIND_FRAC   = 2'd1,
    KIND_SAT    = 2'd2
  } flt_kind_e;
endpackage

// File: rtl/flt_classify.sv
module flt_classify
  import duty_conv_pkg::*;
(
  input  logic [FLT_W-1:0] word,
  output flt_kind_e        kind,
  output logic [EXP_W-1:0] expo,
  output logic [MAN_W-1:0] mant
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);

  flt_t f;
  assign f    = flt_t'(word);
  assign expo = f.expo;
  assign mant = f.mant;

  always_comb begin
    if (f.sign)                                  kind = KIND_ZERO;
    else if (f.expo == EXP_ONES && f.mant != '0) kind = KIND_ZERO;
    else if (f.expo == '0)                       kind = KIND_ZERO;
    else if (f.expo >= EXP_ONE)                  kind = KIND_SAT;
    else                                         kind = KIND_FRAC;
  end
endmodule

// File: rtl/q_convert.sv
module q_convert
  import duty_conv_pkg::*;
#(
  parameter int FRAC_W = 15,
  localparam int FIX_W = FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FLT_W-1:0] in_word,
  output logic             fix_valid,
  output logic [FIX_W-1:0] fix_q
);
  localparam int SIG_W   = MAN_W + 1;
  localparam int SH_BASE = BIAS + MAN_W - FRAC_W;
  localparam logic [FIX_W-1:0] FIX_MAX = {1'b0, {FRAC_W{1'b1}}};

  flt_kind_e        kind;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] mant;
  logic [EXP_W:0]   sh;
  logic [SIG_W-1:0] shifted;
  logic [FIX_W-1:0] fix_next;

  flt_classify u_cls (
    .word (in_word),
    .kind (kind),
    .expo (expo),
    .mant (mant)
  );

  always_comb begin
    sh      = (EXP_W+1)'(SH_BASE) - {1'b0, expo};
    shifted = {1'b1, mant} >> sh;
    unique case (kind)
      KIND_SAT:  fix_next = FIX_MAX;
      KIND_FRAC: fix_next = FIX_W'(shifted);
      default:   fix_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_valid <= 1'b0;
      fix_q     <= '0;
    end else begin
      fix_valid <= in_valid;
      if (in_valid) fix_q <= fix_next;
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> fix_valid);
  p_negative_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[FLT_W-1]) |=> (fix_q == '0));
  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_word[FLT_W-1] && in_word[FLT_W-2 -: EXP_W] >= EXP_W'(BIAS)
     && !(in_word[FLT_W-2 -: EXP_W] == '1 && in_word[MAN_W-1:0] != '0))
    |=> (fix_q == FIX_MAX));
  p_sign_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_q[FIX_W-1]);
endmodule

// File: rtl/period_scale.sv
module period_scale #(
  parameter int FIX_W = 16,
  parameter int PER_W = 16,
  localparam int FRAC_W = FIX_W - 1,
  localparam int PROD_W = FIX_W + PER_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [FIX_W-1:0] fix_q,
  input  logic [PER_W-1:0] period,
  output logic             out_valid,
  output logic [PER_W-1:0] out_ticks
);
  logic signed [FIX_W-1:0]  a_s;
  logic signed [PER_W:0]    b_s;
  logic signed [PROD_W-1:0] prod;
  logic [PER_W-1:0]         ticks_next;

  assign a_s        = $signed(fix_q);
  assign b_s        = $signed({1'b0, period});
  assign prod       = PROD_W'(a_s) * PROD_W'(b_s);
  assign ticks_next = PER_W'(prod >>> FRAC_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ticks <= '0;
    end else begin
      out_valid <= en;
      if (en) out_ticks <= ticks_next;
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> out_valid);
  p_below_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && period != '0 && !fix_q[FIX_W-1]) |=> (out_ticks < $past(period)));
  p_prod_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fix_q[FIX_W-1]) |-> !prod[PROD_W-1]);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_ticks));
endmodule

// File: rtl/duty_tick_conv.sv
module duty_tick_conv
  import duty_conv_pkg::*;
#(
  parameter int FRAC_W = 15,
  parameter int PER_W  = 16,
  localparam int FIX_W = FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [FLT_W-1:0] cmd_float,
  input  logic [PER_W-1:0] period,
  output logic             duty_valid,
  output logic [PER_W-1:0] duty_ticks
);
  logic             fix_valid;
  logic [FIX_W-1:0] fix_q;

  q_convert #(.FRAC_W(FRAC_W)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cmd_valid),
    .in_word   (cmd_float),
    .fix_valid (fix_valid),
    .fix_q     (fix_q)
  );

  period_scale #(.FIX_W(FIX_W), .PER_W(PER_W)) u_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (fix_valid),
    .fix_q     (fix_q),
    .period    (period),
    .out_valid (duty_valid),
    .out_ticks (duty_ticks)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!duty_valid && duty_ticks == '0));
endmodule

// File: tb/duty_tick_conv_bench.sv
module duty_tick_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_float = '0;
  logic [15:0] period = 16'd1000;
  logic        duty_valid;
  logic [15:0] duty_ticks;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  duty_tick_conv u_duty_tick_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_float  (cmd_float),
    .period     (period),
    .duty_valid (duty_valid),
    .duty_ticks (duty_ticks)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one command, result checked after the second edge
  task automatic send(input string req, input logic [31:0] f, input logic [15:0] per,
                      input logic [15:0] exp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_float = f; period = per;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " strobe early"}, {15'd0, duty_valid}, 16'd0);
    @(negedge clk);
    chk({req, " strobe"}, {15'd0, duty_valid}, 16'd1);
    chk(req, duty_ticks, exp);
  endtask

  task automatic t_reset_r1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {15'd0, duty_valid}, 16'd0);
    chk("R1 duty in reset", duty_ticks, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 duty after reset", duty_ticks, 16'd0);
  endtask

  task automatic t_fraction_r5;
    send("R5 half", 32'h3F000000, 16'd1000, 16'd500);
    send("R5 0.3", 32'h3E99999A, 16'd1000, 16'd299);
    send("R5 one third truncated", 32'h3EAAAAAB, 16'd32768, 16'd10922);
    send("R5 2^-15", 32'h38000000, 16'd65535, 16'd1);
    send("R5 2^-16 to zero", 32'h37800000, 16'd65535, 16'd0);
  endtask

  task automatic t_zero_r3;
    send("R3 negative", 32'hBF000000, 16'd1000, 16'd0);
    send("R3 NaN", 32'h7FC00000, 16'd1000, 16'd0);
    send("R3 zero", 32'h00000000, 16'd1000, 16'd0);
    send("R3 subnormal", 32'h00400000, 16'd1000, 16'd0);
  endtask

  task automatic t_saturate_r4;
    send("R4 one", 32'h3F800000, 16'd1000, 16'd999);
    send("R4 infinity", 32'h7F800000, 16'd2000, 16'd1999);
    send("R4 two", 32'h40000000, 16'd100, 16'd99);
  endtask

  task automatic t_scale_r6;
    send("R6 quarter full period", 32'h3E800000, 16'd65535, 16'd16383);
    send("R6 0.75 of 4096", 32'h3F400000, 16'd4096, 16'd3072);
    send("R6 zero period", 32'h3F000000, 16'd0, 16'd0);
  endtask

  task automatic t_back_to_back_r2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_float = 32'h3F000000; period = 16'd800;
    @(negedge clk);
    cmd_float = 32'h3E800000;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 first strobe", {15'd0, duty_valid}, 16'd1);
    chk("R2 first value", duty_ticks, 16'd400);
    @(negedge clk);
    chk("R2 second strobe", {15'd0, duty_valid}, 16'd1);
    chk("R2 second value", duty_ticks, 16'd200);
    @(negedge clk);
    chk("R2 strobe drops", {15'd0, duty_valid}, 16'd0);
  endtask

  task automatic t_hold_r7;
    send("R7 setup", 32'h3F000000, 16'd1000, 16'd500);
    period = 16'd3000;
    repeat (4) @(negedge clk);
    chk("R7 no strobe", {15'd0, duty_valid}, 16'd0);
    chk("R7 held after period change", duty_ticks, 16'd500);
  endtask

  initial begin
    #(4 * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_fraction_r5();
    t_zero_r3();
    t_saturate_r4();
    t_scale_r6();
    t_back_to_back_r2();
    t_hold_r7();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule